// File: doc/BRIEF.md
# Register Supply-State Controller

This block sits beside the physical register file of an out-of-order core and decides, for every physical register, which of three supply levels it runs at: full voltage, a reduced retention voltage that keeps the stored bits, or zero voltage, which loses them. It follows the life of each value through the pipeline rather than counting idle cycles. A register drops to retention once its producer has issued, because it holds nothing useful until the result is committed. It is raised back to full voltage when an access is near. At commit, a value that already had many consumers is assumed to be of little further use, and its register is switched off.

The datapath and the reorder buffer report five kinds of event, each a one-cycle strobe with tags: a destination allocation (register and reorder-buffer entry), a producer issue, a consumer read (register plus the reorder-buffer entry of the producer), an early wake hint, and a commit. Each reorder-buffer entry keeps a saturating count of the consumer reads it served. A read that reaches a register that is not yet usable raises a stall. A read of a switched-off register raises an error.

Top module: `rpc_power_ctrl`

## Requirements
- R1: After reset every register reports the active code 2'b00, all consumer counts are zero, and stall and error are low.
- R2: An issue event moves its register to the drowsy code 2'b01 on the next cycle, unless the register is off or a wake event targets it in the same cycle.
- R3: A wake event (allocation, early wake hint, read, or commit with a count below the threshold) on a drowsy register shows the waking code 2'b11 for exactly WAKE_CYC cycles, then the active code 2'b00.
- R4: A read of a drowsy or waking register raises the stall output in the same cycle. A read of an active register does not stall. The stall output is never high without a read.
- R5: An off register (code 2'b10) leaves that state only through an allocation, which starts a wake. Hints, reads and commits leave it off. A read of an off register raises the error output in the same cycle.
- R6: Each reorder-buffer entry counts the reads accepted against it, saturating at 2**CNT_W-1. An allocation or a commit of that entry clears the count.
- R7: At commit, a count at or above SELDOM_THR switches the register off on the next cycle. A lower count acts as a wake event.
- R8: When a wake event and a sleep event (issue, or a commit that would switch the register off) target the same register in the same cycle, the wake wins and a register that is already active stays active.
- R9: Stall and error are never high together. A read that stalls or errors does not advance any consumer count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| alloc_vld_i | input | 1 | Destination allocation strobe |
| alloc_reg_i | input | $clog2(NUM_REGS) | Allocated physical register |
| alloc_rob_i | input | $clog2(ROB_DEPTH) | Reorder-buffer entry of the allocation |
| issue_vld_i | input | 1 | Producer issue strobe |
| issue_reg_i | input | $clog2(NUM_REGS) | Destination register of the issued producer |
| read_vld_i | input | 1 | Consumer read strobe, held while stalled |
| read_reg_i | input | $clog2(NUM_REGS) | Register being read |
| read_rob_i | input | $clog2(ROB_DEPTH) | Reorder-buffer entry of the value's producer |
| prewake_vld_i | input | 1 | Early wake hint strobe |
| prewake_reg_i | input | $clog2(NUM_REGS) | Register expected to be accessed soon |
| commit_vld_i | input | 1 | Commit strobe |
| commit_reg_i | input | $clog2(NUM_REGS) | Destination register of the committing entry |
| commit_rob_i | input | $clog2(ROB_DEPTH) | Committing reorder-buffer entry |
| pstate_o | output | 2*NUM_REGS | Supply code per register, register r in bits [2r+1:2r] |
| stall_o | output | 1 | Read targets a register that is not yet usable |
| rd_err_o | output | 1 | Read targets a switched-off register |

## Verification
The bench builds the block with 8 registers, 4 reorder-buffer entries, a wake time of 3 cycles, a 2-bit consumer count and a threshold of 2. With so few registers, random strobes often hit the same register in one cycle, which exercises the wake-over-sleep rule. A 2-bit count reaches saturation after three reads, so a fourth read tells saturation apart from wrap-around through the commit outcome. A short wake time keeps the stall windows brief enough to repeat many times in a few thousand cycles.

// File: rtl/rpc_pkg.sv
package rpc_pkg;

    // Supply code per register; the encoding is visible on pstate_o
    typedef enum logic [1:0] {
        PS_ACTIVE = 2'b00,
        PS_DROWSY = 2'b01,
        PS_OFF    = 2'b10,
        PS_WAKING = 2'b11
    } pstate_e;

endpackage

// File: rtl/rpc_use_counters.sv
module rpc_use_counters #(
    parameter int ROB_DEPTH = 16,
    parameter int CNT_W     = 3,
    localparam int IW       = (ROB_DEPTH > 1) ? $clog2(ROB_DEPTH) : 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_a_vld_i,
    input  logic [IW-1:0]    clr_a_idx_i,
    input  logic             clr_b_vld_i,
    input  logic [IW-1:0]    clr_b_idx_i,
    input  logic             inc_vld_i,
    input  logic [IW-1:0]    inc_idx_i,
    input  logic [IW-1:0]    rd_idx_i,
    output logic [CNT_W-1:0] rd_cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [ROB_DEPTH-1:0][CNT_W-1:0] cnt;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        for (int e = 0; e < ROB_DEPTH; e++) begin
            if ((clr_a_vld_i && clr_a_idx_i == IW'(e)) ||
                (clr_b_vld_i && clr_b_idx_i == IW'(e))) begin
                ctr_d.cnt[e] = '0;
            end else if (inc_vld_i && inc_idx_i == IW'(e) && ctr_q.cnt[e] != CNT_MAX) begin
                ctr_d.cnt[e] = ctr_q.cnt[e] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) ctr_q <= '0;
        else         ctr_q <= ctr_d;
    end

    assign rd_cnt_o = ctr_q.cnt[rd_idx_i];

endmodule

// File: rtl/rpc_reg_slot.sv
module rpc_reg_slot
    import rpc_pkg::*;
#(
    parameter int WAKE_CYC = 4,
    localparam int WC_W    = (WAKE_CYC > 1) ? $clog2(WAKE_CYC) : 1
) (
    input  logic    clk_i,
    input  logic    rst_ni,
    input  logic    wake_any_i,     // may also wake an off register
    input  logic    wake_live_i,    // wakes only a register that still holds data
    input  logic    sleep_drowsy_i,
    input  logic    sleep_off_i,
    output pstate_e state_o
);
    typedef struct packed {
        pstate_e          st;
        logic [WC_W-1:0]  wc;
    } slot_t;

    slot_t slot_d, slot_q;
    slot_t adv;
    logic  woke;

    always_comb begin
        // Natural progression of an ongoing wake
        adv = slot_q;
        if (slot_q.st == PS_WAKING) begin
            if (slot_q.wc == '0) adv.st = PS_ACTIVE;
            else                 adv.wc = slot_q.wc - 1'b1;
        end

        woke   = wake_any_i || (wake_live_i && slot_q.st != PS_OFF);
        slot_d = adv;
        if (woke) begin
            if (slot_q.st == PS_DROWSY || slot_q.st == PS_OFF) begin
                slot_d.st = PS_WAKING;
                slot_d.wc = WC_W'(WAKE_CYC - 1);
            end
        end else if (sleep_off_i) begin
            slot_d.st = PS_OFF;
            slot_d.wc = '0;
        end else if (sleep_drowsy_i && slot_q.st != PS_OFF) begin
            slot_d.st = PS_DROWSY;
            slot_d.wc = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) slot_q <= '{st: PS_ACTIVE, wc: '0};
        else         slot_q <= slot_d;
    end

    assign state_o = slot_q.st;

endmodule

// File: rtl/rpc_power_ctrl.sv
module rpc_power_ctrl
    import rpc_pkg::*;
#(
    parameter int NUM_REGS   = 32,
    parameter int ROB_DEPTH  = 16,
    parameter int WAKE_CYC   = 4,
    parameter int CNT_W      = 3,
    parameter int SELDOM_THR = 3,
    localparam int RW        = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int BW        = (ROB_DEPTH > 1) ? $clog2(ROB_DEPTH) : 1
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  alloc_vld_i,
    input  logic [RW-1:0]         alloc_reg_i,
    input  logic [BW-1:0]         alloc_rob_i,
    input  logic                  issue_vld_i,
    input  logic [RW-1:0]         issue_reg_i,
    input  logic                  read_vld_i,
    input  logic [RW-1:0]         read_reg_i,
    input  logic [BW-1:0]         read_rob_i,
    input  logic                  prewake_vld_i,
    input  logic [RW-1:0]         prewake_reg_i,
    input  logic                  commit_vld_i,
    input  logic [RW-1:0]         commit_reg_i,
    input  logic [BW-1:0]         commit_rob_i,
    output logic [2*NUM_REGS-1:0] pstate_o,
    output logic                  stall_o,
    output logic                  rd_err_o
);
    localparam logic [CNT_W-1:0] THR = CNT_W'(SELDOM_THR);

    pstate_e          reg_st [NUM_REGS];
    pstate_e          read_st;
    logic             read_ok;
    logic             seldom;
    logic [CNT_W-1:0] commit_cnt;

    assign read_st  = reg_st[read_reg_i];
    assign read_ok  = read_vld_i && (read_st == PS_ACTIVE);
    assign stall_o  = read_vld_i && (read_st == PS_DROWSY || read_st == PS_WAKING);
    assign rd_err_o = read_vld_i && (read_st == PS_OFF);
    assign seldom   = (commit_cnt >= THR);

    rpc_use_counters #(
        .ROB_DEPTH (ROB_DEPTH),
        .CNT_W     (CNT_W)
    ) u_counts (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .clr_a_vld_i (alloc_vld_i),
        .clr_a_idx_i (alloc_rob_i),
        .clr_b_vld_i (commit_vld_i),
        .clr_b_idx_i (commit_rob_i),
        .inc_vld_i   (read_ok),
        .inc_idx_i   (read_rob_i),
        .rd_idx_i    (commit_rob_i),
        .rd_cnt_o    (commit_cnt)
    );

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_slot
        logic hit_alloc, hit_issue, hit_read, hit_hint, hit_commit;

        assign hit_alloc  = alloc_vld_i   && alloc_reg_i   == RW'(r);
        assign hit_issue  = issue_vld_i   && issue_reg_i   == RW'(r);
        assign hit_read   = read_vld_i    && read_reg_i    == RW'(r);
        assign hit_hint   = prewake_vld_i && prewake_reg_i == RW'(r);
        assign hit_commit = commit_vld_i  && commit_reg_i  == RW'(r);

        rpc_reg_slot #(
            .WAKE_CYC (WAKE_CYC)
        ) u_slot (
            .clk_i          (clk_i),
            .rst_ni         (rst_ni),
            .wake_any_i     (hit_alloc),
            .wake_live_i    (hit_hint || hit_read || (hit_commit && !seldom)),
            .sleep_drowsy_i (hit_issue),
            .sleep_off_i    (hit_commit && seldom),
            .state_o        (reg_st[r])
        );

        assign pstate_o[2*r +: 2] = reg_st[r];
    end

endmodule

// File: rtl/rpc_power_ctrl_chk.sv
module rpc_power_ctrl_chk
    import rpc_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int RW       = 5
) (
    input logic                  clk_i,
    input logic                  rst_ni,
    input logic                  alloc_vld_i,
    input logic [RW-1:0]         alloc_reg_i,
    input logic                  issue_vld_i,
    input logic [RW-1:0]         issue_reg_i,
    input logic                  read_vld_i,
    input logic [RW-1:0]         read_reg_i,
    input logic                  prewake_vld_i,
    input logic [RW-1:0]         prewake_reg_i,
    input logic                  commit_vld_i,
    input logic [RW-1:0]         commit_reg_i,
    input logic [2*NUM_REGS-1:0] pstate_o,
    input logic                  stall_o,
    input logic                  rd_err_o
);
    function automatic logic [1:0] st_at(input logic [RW-1:0] idx);
        return pstate_o[2*int'(idx) +: 2];
    endfunction

    logic issue_alone;
    assign issue_alone = issue_vld_i
        && !(alloc_vld_i   && alloc_reg_i   == issue_reg_i)
        && !(read_vld_i    && read_reg_i    == issue_reg_i)
        && !(prewake_vld_i && prewake_reg_i == issue_reg_i)
        && !(commit_vld_i  && commit_reg_i  == issue_reg_i);

    p_reset_active_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(!rst_ni) |-> (pstate_o == '0));

    p_issue_drowsy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (issue_alone && st_at(issue_reg_i) != PS_OFF)
        |=> (st_at($past(issue_reg_i)) == PS_DROWSY));

    p_read_starts_wake_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (read_vld_i && st_at(read_reg_i) == PS_DROWSY)
        |=> (st_at($past(read_reg_i)) == PS_WAKING));

    p_stall_needs_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stall_o |-> read_vld_i);

    p_wake_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (issue_vld_i && prewake_vld_i && issue_reg_i == prewake_reg_i
         && st_at(issue_reg_i) == PS_ACTIVE)
        |=> (st_at($past(issue_reg_i)) == PS_ACTIVE));

    p_stall_err_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(stall_o && rd_err_o));

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_off
        p_off_holds_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (pstate_o[2*r +: 2] == PS_OFF && !(alloc_vld_i && alloc_reg_i == RW'(r)))
            |=> (pstate_o[2*r +: 2] == PS_OFF));
    end

endmodule

bind rpc_power_ctrl rpc_power_ctrl_chk #(
    .NUM_REGS (NUM_REGS),
    .RW       (RW)
) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .alloc_vld_i   (alloc_vld_i),
    .alloc_reg_i   (alloc_reg_i),
    .issue_vld_i   (issue_vld_i),
    .issue_reg_i   (issue_reg_i),
    .read_vld_i    (read_vld_i),
    .read_reg_i    (read_reg_i),
    .prewake_vld_i (prewake_vld_i),
    .prewake_reg_i (prewake_reg_i),
    .commit_vld_i  (commit_vld_i),
    .commit_reg_i  (commit_reg_i),
    .pstate_o      (pstate_o),
    .stall_o       (stall_o),
    .rd_err_o      (rd_err_o)
);

// File: tb/rpc_power_ctrl_test.sv
module rpc_power_ctrl_test;
    localparam int NR  = 8;
    localparam int RD  = 4;
    localparam int W   = 3;
    localparam int CW  = 2;
    localparam int THR = 2;
    localparam int RW  = 3;
    localparam int BW  = 2;
    localparam int CMAX = 3;
    localparam int ACT = 0, DRW = 1, OFF = 2, WKG = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alloc_vld = 0, issue_vld = 0, read_vld = 0, hint_vld = 0, commit_vld = 0;
    logic [RW-1:0] alloc_reg = 0, issue_reg = 0, read_reg = 0, hint_reg = 0, commit_reg = 0;
    logic [BW-1:0] alloc_rob = 0, read_rob = 0, commit_rob = 0;
    logic [2*NR-1:0] pstate;
    logic stall, rd_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int m_st  [NR];
    int m_wc  [NR];
    int m_cnt [RD];

    always #10 clk = ~clk;

    rpc_power_ctrl #(
        .NUM_REGS (NR), .ROB_DEPTH (RD), .WAKE_CYC (W), .CNT_W (CW), .SELDOM_THR (THR)
    ) uut (
        .clk_i (clk), .rst_ni (rst_n),
        .alloc_vld_i (alloc_vld), .alloc_reg_i (alloc_reg), .alloc_rob_i (alloc_rob),
        .issue_vld_i (issue_vld), .issue_reg_i (issue_reg),
        .read_vld_i (read_vld), .read_reg_i (read_reg), .read_rob_i (read_rob),
        .prewake_vld_i (hint_vld), .prewake_reg_i (hint_reg),
        .commit_vld_i (commit_vld), .commit_reg_i (commit_reg), .commit_rob_i (commit_rob),
        .pstate_o (pstate), .stall_o (stall), .rd_err_o (rd_err)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int st_of(input int r);
        return int'(pstate[2*r +: 2]);
    endfunction

    function automatic logic [2*NR-1:0] model_vec();
        logic [2*NR-1:0] v;
        for (int r = 0; r < NR; r++) v[2*r +: 2] = 2'(m_st[r]);
        return v;
    endfunction

    task automatic clear_inputs();
        alloc_vld = 0; issue_vld = 0; read_vld = 0; hint_vld = 0; commit_vld = 0;
    endtask

    // One cycle: check combinational outputs, advance model, check state
    task automatic tick();
        int  n_st [NR];
        int  n_wc [NR];
        int  n_cnt [RD];
        int  rs;
        bit  e_stall, e_err, seld, accepted;
        #1;
        rs      = m_st[read_reg];
        e_stall = read_vld && (rs == DRW || rs == WKG);
        e_err   = read_vld && (rs == OFF);
        chk({stall, rd_err} == {e_stall, e_err}, "R4 R5 R9 stall/err",
            {stall, rd_err}, {e_stall, e_err});
        seld     = m_cnt[commit_rob] >= THR;
        accepted = read_vld && rs == ACT;
        for (int r = 0; r < NR; r++) begin
            bit wa, wg, so, sd;
            wa = alloc_vld && alloc_reg == r;
            wg = (hint_vld && hint_reg == r) || (read_vld && read_reg == r)
                 || (commit_vld && commit_reg == r && !seld);
            so = commit_vld && commit_reg == r && seld;
            sd = issue_vld && issue_reg == r;
            n_st[r] = m_st[r];
            n_wc[r] = m_wc[r];
            if (m_st[r] == WKG) begin
                if (m_wc[r] == 0) n_st[r] = ACT;
                else              n_wc[r] = m_wc[r] - 1;
            end
            if (wa || (wg && m_st[r] != OFF)) begin
                if (m_st[r] == DRW || m_st[r] == OFF) begin
                    n_st[r] = WKG; n_wc[r] = W - 1;
                end
            end else if (so) begin
                n_st[r] = OFF; n_wc[r] = 0;
            end else if (sd && m_st[r] != OFF) begin
                n_st[r] = DRW; n_wc[r] = 0;
            end
        end
        for (int e = 0; e < RD; e++) begin
            n_cnt[e] = m_cnt[e];
            if ((alloc_vld && alloc_rob == e) || (commit_vld && commit_rob == e))
                n_cnt[e] = 0;
            else if (accepted && read_rob == e && m_cnt[e] < CMAX)
                n_cnt[e] = m_cnt[e] + 1;
        end
        @(posedge clk);
        for (int r = 0; r < NR; r++) begin m_st[r] = n_st[r]; m_wc[r] = n_wc[r]; end
        for (int e = 0; e < RD; e++) m_cnt[e] = n_cnt[e];
        @(negedge clk);
        chk(pstate == model_vec(), "R2 R3 R5 R6 R7 R8 state vector", pstate, model_vec());
        clear_inputs();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        void'($urandom(32'd4242));
        for (int r = 0; r < NR; r++) begin m_st[r] = ACT; m_wc[r] = 0; end
        for (int e = 0; e < RD; e++) m_cnt[e] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(pstate == '0, "R1 reset codes", pstate, 0);
        chk({stall, rd_err} == 2'b00, "R1 reset stall/err", {stall, rd_err}, 0);

        // R2: issue drops register 1 to drowsy
        issue_vld = 1; issue_reg = 1; tick();
        chk(st_of(1) == DRW, "R2 issue to drowsy", st_of(1), DRW);

        // R3 R4: held read on drowsy register stalls 1+W cycles, W of them waking
        n = 0;
        for (int i = 0; i < 10; i++) begin
            int wk;
            wk = (st_of(1) == WKG) ? 1 : 0;
            read_vld = 1; read_reg = 1; read_rob = 0;
            #1;
            if (!stall) break;
            n += 1 + 100 * wk;
            tick();
        end
        chk(n == 1 + 101 * W, "R3 R4 stall and waking span", n, 1 + 101 * W);
        chk(st_of(1) == ACT, "R3 active after wake", st_of(1), ACT);
        tick();

        // R6 R7: four accepted reads saturate at 3, commit switches register 2 off
        alloc_vld = 1; alloc_reg = 2; alloc_rob = 1; tick();
        for (int i = 0; i < 4; i++) begin
            read_vld = 1; read_reg = 2; read_rob = 1; tick();
        end
        commit_vld = 1; commit_reg = 2; commit_rob = 1; tick();
        chk(st_of(2) == OFF, "R6 R7 saturated count turns off", st_of(2), OFF);

        // R5: off register errors on read, ignores hint, woken by allocation
        read_vld = 1; read_reg = 2; read_rob = 1;
        #1;
        chk({stall, rd_err} == 2'b01, "R5 read of off register", {stall, rd_err}, 1);
        tick();
        hint_vld = 1; hint_reg = 2; tick();
        chk(st_of(2) == OFF, "R5 hint ignored when off", st_of(2), OFF);
        alloc_vld = 1; alloc_reg = 2; alloc_rob = 2; tick();
        chk(st_of(2) == WKG, "R5 allocation wakes off register", st_of(2), WKG);

        // R7: commit with low count wakes a drowsy register
        alloc_vld = 1; alloc_reg = 3; alloc_rob = 3; tick();
        issue_vld = 1; issue_reg = 3; tick();
        commit_vld = 1; commit_reg = 3; commit_rob = 3; tick();
        chk(st_of(3) == WKG, "R7 low count commit wakes", st_of(3), WKG);

        // R8: issue and hint on active register 4 in one cycle
        issue_vld = 1; issue_reg = 4; hint_vld = 1; hint_reg = 4; tick();
        chk(st_of(4) == ACT, "R8 wake beats sleep", st_of(4), ACT);

        // R9: stalled reads do not count; one accepted read stays below threshold
        repeat (W + 1) tick();
        alloc_vld = 1; alloc_reg = 5; alloc_rob = 0; tick();
        issue_vld = 1; issue_reg = 5; tick();
        for (int i = 0; i < 10; i++) begin
            read_vld = 1; read_reg = 5; read_rob = 0;
            #1;
            if (!stall) begin tick(); break; end
            tick();
        end
        commit_vld = 1; commit_reg = 5; commit_rob = 0; tick();
        chk(st_of(5) != OFF, "R9 stalled reads not counted", st_of(5), ACT);

        // Random mixed traffic checked against the model
        for (int c = 0; c < 3000; c++) begin
            alloc_vld  = ($urandom % 5) == 0; alloc_reg  = RW'($urandom); alloc_rob  = BW'($urandom);
            issue_vld  = ($urandom % 3) == 0; issue_reg  = RW'($urandom);
            read_vld   = ($urandom % 2) == 0; read_reg   = RW'($urandom); read_rob   = BW'($urandom);
            hint_vld   = ($urandom % 4) == 0; hint_reg   = RW'($urandom);
            commit_vld = ($urandom % 4) == 0; commit_reg = RW'($urandom); commit_rob = BW'($urandom);
            tick();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule